// File: doc/BRIEF.md
# Two-Level Priority Channel Arbiter

This block decides which of seven transfer channels may use a shared bus access sequencer next. Each channel presents a request line, an enable bit and a two-bit priority level. When the sequencer is free, the arbiter looks only at channels that are both requesting and enabled. It picks the highest priority level among them. If several channels share that level, the lowest channel number wins.

The winner gets a one-hot grant, its channel number and a valid flag. The grant is held until the transfer engine reports, with a single-cycle done strobe, that the one data item has moved. The grant then turns into an acknowledge to that channel's requester. The acknowledge stays up until the requester withdraws its request. Only after that does the arbiter pick again. This gives every request exactly one data item, and a channel has to lower its request before it can ask again.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After reset, `grantVec`, `grantIdx` and `ackVec` are all zero and `grantValid` is low.
- R2: Channel i's level sits in `prioVec[2i+1:2i]`, with 2'b11 the most urgent and 2'b00 the least. Among enabled requesting channels, one with a strictly higher level always wins.
- R3: Among enabled requesting channels that share the highest level present, the one with the lowest index wins.
- R4: A channel whose `chanEn` bit is low is never granted, whatever its level. If every requesting channel is disabled, nothing is granted.
- R5: If a candidate is present at a clock edge while the arbiter is idle, then from that edge on the winner's bit is the only bit set in `grantVec`, `grantIdx` holds its number and `grantValid` is high.
- R6: While a grant is held and `xferDone` is low, the grant stays unchanged, even if new or more urgent requests arrive.
- R7: A clock edge that samples `xferDone` high during a grant clears the grant outputs and raises the winner's bit in `ackVec`.
- R8: `ackVec` stays up until an edge samples the owner's request low. From that edge on it is zero, and the next arbitration happens at the following edge.
- R9: With no enabled request, `grantVec` is zero, `grantIdx` is zero and `grantValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| chanReq | input | 7 | Request line for each channel |
| chanEn | input | 7 | Enable for each channel |
| prioVec | input | 14 | Two-bit priority for each channel, channel i at bits [2i+1:2i] |
| xferDone | input | 1 | One-cycle strobe from the transfer engine: the data item is finished |
| grantVec | output | 7 | One-hot grant to the winning channel |
| grantIdx | output | 3 | Number of the granted channel, zero when idle |
| grantValid | output | 1 | High while a grant is held |
| ackVec | output | 7 | Acknowledge to the owner's requester, held until the request drops |

## Verification
Each result is due one clock edge after the input that causes it. A candidate sampled while idle shows up as a grant after that edge. A done strobe turns the grant into an acknowledge after one edge, and a dropped request clears the acknowledge after one edge. The next grant can appear no sooner than one edge after that. The bench changes its inputs only on falling edges. A behavioural reference model steps at each rising edge, and all four outputs are compared with it at the falling edge that follows. Every result is therefore checked in exactly the cycle it is due.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_ACK  = 2'd2
  } arbState_t;

  typedef struct packed {
    logic load;     // capture the winner this edge
    logic grantOn;  // a grant is being held
    logic ackOn;    // acknowledge is being held
  } arbStrb_t;
endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     candValid,
  input  logic     xferDone,
  input  logic     ownerReq,
  output arbStrb_t strb
);
  arbState_t state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (candValid) stateNext = ST_BUSY;
      ST_BUSY: if (xferDone)  stateNext = ST_ACK;
      ST_ACK:  if (!ownerReq) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb.load    = (state == ST_IDLE) && candValid;
    strb.grantOn = (state == ST_BUSY);
    strb.ackOn   = (state == ST_ACK);
  end

  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    strb.grantOn && !xferDone |=> strb.grantOn); // R6
  AST_DONE_TO_ACK: assert property (@(posedge clk) disable iff (!rstN)
    strb.grantOn && xferDone |=> strb.ackOn && !strb.grantOn); // R7
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackOn && ownerReq |=> strb.ackOn); // R8
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackOn && !ownerReq |=> !strb.ackOn && !strb.grantOn); // R8
endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int LVL_W  = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CH-1:0]       chanReq,
  input  logic [NUM_CH-1:0]       chanEn,
  input  logic [NUM_CH*LVL_W-1:0] prioVec,
  input  arbStrb_t                strb,
  output logic                    candValid,
  output logic                    ownerReq,
  output logic [NUM_CH-1:0]       grantVec,
  output logic [$clog2(NUM_CH)-1:0] grantIdx,
  output logic                    grantValid,
  output logic [NUM_CH-1:0]       ackVec
);
  localparam int IDX_W = $clog2(NUM_CH);

  logic [LVL_W-1:0]  chLvl [NUM_CH];
  logic [NUM_CH-1:0] cand;
  logic              selFound;
  logic [IDX_W-1:0]  selIdx;
  logic [LVL_W-1:0]  selLvl;
  logic [IDX_W-1:0]  ownerIdx;
  logic [NUM_CH-1:0] ownerVec;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
    assign chLvl[g] = prioVec[g*LVL_W +: LVL_W];
  end

  assign cand = chanReq & chanEn;

  // Scan from the top index down; ">=" lets a lower index take over a tie.
  always_comb begin
    selFound = 1'b0;
    selIdx   = '0;
    selLvl   = '0;
    for (int ch = NUM_CH - 1; ch >= 0; ch--) begin
      if (cand[ch] && (!selFound || chLvl[ch] >= selLvl)) begin
        selFound = 1'b1;
        selIdx   = IDX_W'(ch);
        selLvl   = chLvl[ch];
      end
    end
  end

  assign candValid = selFound;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownerIdx <= '0;
      ownerVec <= '0;
    end else if (strb.load) begin
      ownerIdx <= selIdx;
      ownerVec <= NUM_CH'(1) << selIdx;
    end
  end

  assign ownerReq   = |(ownerVec & chanReq);
  assign grantValid = strb.grantOn;
  assign grantVec   = strb.grantOn ? ownerVec : '0;
  assign grantIdx   = strb.grantOn ? ownerIdx : '0;
  assign ackVec     = strb.ackOn ? ownerVec : '0;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec) && (grantValid == (grantVec != '0))); // R5
  AST_GRANT_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grantValid) |-> (grantVec & $past(chanReq & chanEn)) != '0); // R4
  AST_NO_GRANT_WITH_ACK: assert property (@(posedge clk) disable iff (!rstN)
    !(grantValid && ackVec != '0)); // R7
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int LVL_W  = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_CH-1:0]         chanReq,
  input  logic [NUM_CH-1:0]         chanEn,
  input  logic [NUM_CH*LVL_W-1:0]   prioVec,
  input  logic                      xferDone,
  output logic [NUM_CH-1:0]         grantVec,
  output logic [$clog2(NUM_CH)-1:0] grantIdx,
  output logic                      grantValid,
  output logic [NUM_CH-1:0]         ackVec
);
  arbStrb_t strb;
  logic     candValid;
  logic     ownerReq;

  arb_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .candValid (candValid),
    .xferDone  (xferDone),
    .ownerReq  (ownerReq),
    .strb      (strb)
  );

  arb_datapath #(.NUM_CH(NUM_CH), .LVL_W(LVL_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .chanReq    (chanReq),
    .chanEn     (chanEn),
    .prioVec    (prioVec),
    .strb       (strb),
    .candValid  (candValid),
    .ownerReq   (ownerReq),
    .grantVec   (grantVec),
    .grantIdx   (grantIdx),
    .grantValid (grantValid),
    .ackVec     (ackVec)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !grantValid |-> grantVec == '0 && grantIdx == '0); // R9
endmodule

// File: tb/test_dma_prio_arbiter.sv
module test_dma_prio_arbiter;
  localparam int NCH = 7;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NCH-1:0] chanReq = '0;
  logic [NCH-1:0] chanEn = '0;
  logic [2*NCH-1:0] prioVec = '0;
  logic           xferDone = 1'b0;
  logic [NCH-1:0] grantVec;
  logic [2:0]     grantIdx;
  logic           grantValid;
  logic [NCH-1:0] ackVec;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state: 0 idle, 1 granted, 2 acknowledging
  int mState = 0;
  int mOwner = 0;

  always #5 clk = ~clk;

  dma_prio_arbiter i_dma_prio_arbiter (
    .clk(clk), .rstN(rstN), .chanReq(chanReq), .chanEn(chanEn),
    .prioVec(prioVec), .xferDone(xferDone), .grantVec(grantVec),
    .grantIdx(grantIdx), .grantValid(grantValid), .ackVec(ackVec));

  function automatic int pickWinner();
    for (int lv = 3; lv >= 0; lv--)
      for (int c = 0; c < NCH; c++)
        if (chanReq[c] && chanEn[c] && int'(prioVec[2*c +: 2]) == lv) return c;
    return -1;
  endfunction

  task automatic modelStep();
    int w;
    if (!rstN) begin mState = 0; mOwner = 0; return; end
    case (mState)
      0: begin w = pickWinner(); if (w >= 0) begin mOwner = w; mState = 1; end end
      1: if (xferDone) mState = 2;
      default: if (!chanReq[mOwner]) mState = 0;
    endcase
  endtask

  task automatic expectEq(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    int eg = (mState == 1) ? (1 << mOwner) : 0;
    expectEq(tag, "grantVec", int'(grantVec), eg);
    expectEq(tag, "grantIdx", int'(grantIdx), (mState == 1) ? mOwner : 0);
    expectEq(tag, "grantValid", int'(grantValid), (mState == 1) ? 1 : 0);
    expectEq(tag, "ackVec", int'(ackVec), (mState == 2) ? (1 << mOwner) : 0);
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic setLvl(int c, int lv);
    prioVec[2*c +: 2] = 2'(lv);
  endtask

  // Serve one grant: hold, optionally add a disturbing request, finish, drop.
  task automatic serve(string tag, int expWin, int disturb);
    for (int i = 0; i < 4 && mState != 1; i++) tick(tag);
    expectEq(tag, "winner", int'(grantIdx), expWin);
    if (disturb >= 0) begin chanReq[disturb] = 1'b1; chanEn[disturb] = 1'b1; setLvl(disturb, 3); end
    tick("R6");
    tick("R6");
    xferDone = 1'b1;
    tick("R7");
    xferDone = 1'b0;
    tick("R8");
    tick("R8");
    chanReq[mOwner] = 1'b0;
    tick("R8");
  endtask

  task automatic clearAll();
    chanReq = '0; chanEn = '0; prioVec = '0; xferDone = 1'b0;
    tick("R9");
    tick("R9");
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    compareAll("R1");
    @(negedge clk);
    rstN = 1'b1;
    compareAll("R1");
    tick("R9");
    tick("R9");

    // R2: higher level beats lower index
    chanEn = '1; chanReq[3] = 1'b1; setLvl(3, 0); chanReq[5] = 1'b1; setLvl(5, 1);
    serve("R2", 5, -1);
    clearAll();
    chanEn = '1; chanReq[0] = 1'b1; setLvl(0, 2); chanReq[6] = 1'b1; setLvl(6, 3);
    serve("R2", 6, 2);
    clearAll();

    // R3: equal levels, lowest index wins
    chanEn = '1; chanReq[2] = 1'b1; setLvl(2, 2); chanReq[4] = 1'b1; setLvl(4, 2);
    serve("R3", 2, -1);
    tick("R3");
    serve("R3", 4, -1);
    clearAll();
    chanEn = '1; for (int c = 0; c < NCH; c++) begin chanReq[c] = 1'b1; setLvl(c, 1); end
    setLvl(3, 3); setLvl(5, 3);
    serve("R3", 3, -1);
    clearAll();

    // R4: disabled channels never win
    chanReq[0] = 1'b1; setLvl(0, 3); chanEn[0] = 1'b0;
    chanReq[6] = 1'b1; setLvl(6, 0); chanEn[6] = 1'b1;
    serve("R4", 6, -1);
    clearAll();
    chanReq = '1; chanEn = '0; prioVec = '1;
    for (int i = 0; i < 4; i++) tick("R4");
    clearAll();

    // R5: single candidate, every index
    for (int c = 0; c < NCH; c++) begin
      chanEn = '1; chanReq[c] = 1'b1; setLvl(c, c % 4);
      tick("R5");
      serve("R5", c, -1);
      clearAll();
    end

    // R9: enables without requests
    chanEn = '1; prioVec = '1;
    for (int i = 0; i < 3; i++) tick("R9");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule